// File: doc/BRIEF.md
# Reset and Chip-Enable Sequencer

This block produces the internal core reset of a video front end and an active-low reset indicator that other parts of the system can use. A reset starts on any of five conditions: the power-on reset input, an active-low chip-enable pin pulled low, a digital-rail undervoltage flag, an analog-rail undervoltage flag, or a missing line-locked clock. The missing-clock condition is found by a watchdog that runs on a separate always-on clock.

A reset is applied at once, without waiting for a clock edge. Release is timed by the line-locked clock. While reset is active, every managed output enable is low, so the pads are in high impedance. After release, three fixed outputs turn back on by themselves: the main clock, the half-rate clock and the serial data line. The programmable outputs stay off until software writes their enable register. The indicator is held low for a fixed number of line-clock cycles after release. A status code records the most recent reset cause until software clears it.

Top module: `chip_rst_seq`

## Requirements
- R1: If the power-on reset is low, the chip enable is low, either undervoltage flag is set, or the line clock is missing, then `core_rst_no` and `rst_ind_no` go low and every bit of `oe_fixed_o` and `oe_prog_o` is 0. This holds for as long as the cause lasts. The level inputs are sampled on the always-on clock and must be held for at least 3 of its cycles.
- R2: If the line clock shows no rising edge for more than `WD_LIMIT` always-on cycles, the clock counts as missing. Once edges return, the missing condition ends.
- R3: Reset release is timed by the line clock. `core_rst_no` rises no sooner than 2 line-clock edges after the internal reset request falls. With the default clocks this is 30 to 55 ns after the last cause is removed.
- R4: After `core_rst_no` rises, `rst_ind_no` stays low for exactly `IND_CYCLES` (128) line-clock cycles and then goes high. It is never high while `core_rst_no` is low.
- R5: If any cause returns while the indicator count is running, the count restarts. The indicator then stays low for a full `IND_CYCLES` cycles after the later release.
- R6: `oe_fixed_o` returns to all ones as soon as `core_rst_no` is high, with no software action. Bit 0 enables the main clock, bit 1 the half-rate clock and bit 2 the serial data line.
- R7: Every reset clears `oe_prog_o` to 0. While out of reset, a line-clock cycle with `oe_we_i` high loads `oe_wdata_i` into the register. A write made during reset has no effect.
- R8: `cause_o` encodes the most recently appearing cause: 0 none, 1 missing clock, 2 digital undervoltage, 3 analog undervoltage, 4 chip enable. If several causes appear in the same cycle, the priority is 1 > 2 > 3 > 4. The code is held after the cause goes away. The power-on reset sets it to 0.
- R9: A one-cycle pulse on `cause_clr_i` (always-on domain) sets `cause_o` to 0. It does not disturb the reset outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aon_clk_i | input | 1 | Always-on clock for the watchdog, the synchronisers and the status logic |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| line_clk_i | input | 1 | Line-locked clock, which may stop |
| chip_en_ni | input | 1 | Chip enable, active low |
| dig_uv_i | input | 1 | Digital-rail undervoltage flag |
| ana_uv_i | input | 1 | Analog-rail undervoltage flag |
| oe_we_i | input | 1 | Write strobe for the programmable enable register (line domain) |
| oe_wdata_i | input | N_PROG | Write data for the programmable enable register |
| cause_clr_i | input | 1 | Clears the cause status (always-on domain) |
| core_rst_no | output | 1 | Internal core reset, active low |
| rst_ind_no | output | 1 | Delayed reset indicator, active low |
| oe_fixed_o | output | 3 | Enables that return by themselves (main clock, half clock, serial data) |
| oe_prog_o | output | N_PROG | Software-controlled output enables |
| cause_o | output | 3 | Code of the most recent reset cause |

## Verification
Some properties are checked by assertions on every cycle:
- every enable is off while the core is in reset;
- the indicator is never high while the core is in reset, and rises only after the core has been out of reset for some cycles;
- the programmable enables come back at zero;
- the cause code stays within its five legal values.

Other behaviours can only be shown by the bench's scenarios:
- the exact 128-cycle indicator length and its restart when a cause returns;
- the release latency in nanoseconds;
- detection of a stopped line clock and recovery once it runs again;
- the priority between causes that appear together, and the hold and clear behaviour of the status code.

// File: rtl/chip_rst_seq_pkg.sv
package chip_rst_seq_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_CLK  = 3'd1,
    CAUSE_DUV  = 3'd2,
    CAUSE_AUV  = 3'd3,
    CAUSE_CHIP = 3'd4
  } cause_e;

  localparam int CAUSE_W   = 3;
  localparam int NUM_CAUSE = 4;   // index order = priority order, lowest wins
  localparam int NUM_FIXED = 3;
  localparam int FIX_MAIN  = 0;
  localparam int FIX_HALF  = 1;
  localparam int FIX_SDATA = 2;

endpackage

// File: rtl/rsq_sync2.sv
module rsq_sync2 #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

endmodule

// File: rtl/rsq_clk_watchdog.sv
module rsq_clk_watchdog #(
  parameter int LIMIT = 16
) (
  input  logic aon_clk_i,
  input  logic rst_ni,
  input  logic line_clk_i,
  output logic missing_o
);

  localparam int             CW   = $clog2(LIMIT + 1);
  localparam logic [CW-1:0]  CMAX = CW'(LIMIT);

  logic          tgl_q;
  logic          tgl_s, tgl_d1;
  logic          edge_seen;
  logic [CW-1:0] cnt_q;
  logic          miss_q;

  // toggles on every line edge; must not be held by the core reset
  always_ff @(posedge line_clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  rsq_sync2 #(.W(1), .RST_VAL(1'b0)) u_tgl_sync (
    .clk_i  (aon_clk_i),
    .rst_ni (rst_ni),
    .d_i    (tgl_q),
    .q_o    (tgl_s)
  );

  assign edge_seen = tgl_s ^ tgl_d1;

  always_ff @(posedge aon_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_d1 <= 1'b0;
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      tgl_d1 <= tgl_s;
      if (edge_seen)          cnt_q <= '0;
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      miss_q <= (cnt_q == CMAX) && !edge_seen;
    end
  end

  assign missing_o = miss_q;

endmodule

// File: rtl/rsq_cause_track.sv
module rsq_cause_track
  import chip_rst_seq_pkg::*;
(
  input  logic                 aon_clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CAUSE-1:0] cause_i,
  input  logic                 clr_i,
  output cause_e               code_o,
  output logic                 req_o
);

  logic [NUM_CAUSE-1:0] prev_q;
  logic [NUM_CAUSE-1:0] rise;
  cause_e               code_q, code_d;
  logic                 req_q;

  assign rise = cause_i & ~prev_q;

  // a newly appearing cause beats a clear in the same cycle
  always_comb begin
    code_d = code_q;
    if (clr_i) code_d = CAUSE_NONE;
    for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
      if (rise[i]) code_d = cause_e'(CAUSE_W'(i + 1));
    end
  end

  always_ff @(posedge aon_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      code_q <= CAUSE_NONE;
      req_q  <= 1'b1;
    end else begin
      prev_q <= cause_i;
      code_q <= code_d;
      req_q  <= |cause_i;
    end
  end

  assign code_o = code_q;
  assign req_o  = req_q;

endmodule

// File: rtl/rsq_rst_release.sv
module rsq_rst_release #(
  parameter int IND_CYCLES = 128
) (
  input  logic line_clk_i,
  input  logic arst_ni,
  output logic core_rst_no,
  output logic ind_no
);

  localparam int            CW   = (IND_CYCLES > 2) ? $clog2(IND_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(IND_CYCLES - 1);

  logic          r1_q, r2_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  // asynchronous assertion, release after two line edges
  always_ff @(posedge line_clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      r1_q   <= 1'b0;
      r2_q   <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
      if (r2_q && !done_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) done_q <= 1'b1;
      end
    end
  end

  assign core_rst_no = r2_q;
  assign ind_no      = done_q;

endmodule

// File: rtl/rsq_oe_ctrl.sv
module rsq_oe_ctrl
  import chip_rst_seq_pkg::*;
#(
  parameter int N_PROG = 8
) (
  input  logic                 line_clk_i,
  input  logic                 core_rst_ni,
  input  logic                 we_i,
  input  logic [N_PROG-1:0]    wdata_i,
  output logic [NUM_FIXED-1:0] fixed_o,
  output logic [N_PROG-1:0]    prog_o
);

  logic [N_PROG-1:0] prog_q;

  for (genvar g = 0; g < NUM_FIXED; g++) begin : g_fixed
    assign fixed_o[g] = core_rst_ni;
  end

  always_ff @(posedge line_clk_i or negedge core_rst_ni) begin
    if (!core_rst_ni) prog_q <= '0;
    else if (we_i)    prog_q <= wdata_i;
  end

  assign prog_o = prog_q;

endmodule

// File: rtl/chip_rst_seq.sv
module chip_rst_seq
  import chip_rst_seq_pkg::*;
#(
  parameter int WD_LIMIT   = 16,
  parameter int IND_CYCLES = 128,
  parameter int N_PROG     = 8
) (
  input  logic                 aon_clk_i,
  input  logic                 rst_ni,
  input  logic                 line_clk_i,
  input  logic                 chip_en_ni,
  input  logic                 dig_uv_i,
  input  logic                 ana_uv_i,
  input  logic                 oe_we_i,
  input  logic [N_PROG-1:0]    oe_wdata_i,
  input  logic                 cause_clr_i,
  output logic                 core_rst_no,
  output logic                 rst_ind_no,
  output logic [NUM_FIXED-1:0] oe_fixed_o,
  output logic [N_PROG-1:0]    oe_prog_o,
  output logic [CAUSE_W-1:0]   cause_o
);

  logic                 clk_missing;
  logic [2:0]           lvl_s;
  logic [NUM_CAUSE-1:0] cause_vec;
  cause_e               code;
  logic                 rst_req;
  logic                 line_arst_n;

  rsq_clk_watchdog #(.LIMIT(WD_LIMIT)) u_wdog (
    .aon_clk_i  (aon_clk_i),
    .rst_ni     (rst_ni),
    .line_clk_i (line_clk_i),
    .missing_o  (clk_missing)
  );

  // bit2 chip enable (idle high), bit1 analog flag, bit0 digital flag
  rsq_sync2 #(.W(3), .RST_VAL(3'b100)) u_lvl_sync (
    .clk_i  (aon_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({chip_en_ni, ana_uv_i, dig_uv_i}),
    .q_o    (lvl_s)
  );

  assign cause_vec = {~lvl_s[2], lvl_s[1], lvl_s[0], clk_missing};

  rsq_cause_track u_cause (
    .aon_clk_i (aon_clk_i),
    .rst_ni    (rst_ni),
    .cause_i   (cause_vec),
    .clr_i     (cause_clr_i),
    .code_o    (code),
    .req_o     (rst_req)
  );

  assign line_arst_n = rst_ni & ~rst_req;

  rsq_rst_release #(.IND_CYCLES(IND_CYCLES)) u_rel (
    .line_clk_i  (line_clk_i),
    .arst_ni     (line_arst_n),
    .core_rst_no (core_rst_no),
    .ind_no      (rst_ind_no)
  );

  rsq_oe_ctrl #(.N_PROG(N_PROG)) u_oe (
    .line_clk_i  (line_clk_i),
    .core_rst_ni (core_rst_no),
    .we_i        (oe_we_i),
    .wdata_i     (oe_wdata_i),
    .fixed_o     (oe_fixed_o),
    .prog_o      (oe_prog_o)
  );

  assign cause_o = code;

endmodule

// File: rtl/chip_rst_seq_chk.sv
module chip_rst_seq_chk #(
  parameter int N_PROG = 8
) (
  input logic              aon_clk_i,
  input logic              line_clk_i,
  input logic              rst_ni,
  input logic              core_rst_no,
  input logic              rst_ind_no,
  input logic [2:0]        oe_fixed_o,
  input logic [N_PROG-1:0] oe_prog_o,
  input logic [2:0]        cause_o
);

  a_r1_enables_off_in_reset: assert property (@(posedge aon_clk_i) disable iff (!rst_ni)
    !core_rst_no |-> (oe_fixed_o == '0 && oe_prog_o == '0));

  a_r4_ind_low_in_reset: assert property (@(posedge line_clk_i) disable iff (!rst_ni)
    !core_rst_no |-> !rst_ind_no);

  a_r4_ind_rise_late: assert property (@(posedge line_clk_i) disable iff (!rst_ni)
    $rose(rst_ind_no) |-> ($past(core_rst_no, 1) && $past(core_rst_no, 2)));

  a_r7_prog_clear_on_release: assert property (@(posedge line_clk_i) disable iff (!rst_ni)
    $rose(core_rst_no) |-> oe_prog_o == '0);

  a_r8_code_legal: assert property (@(posedge aon_clk_i) disable iff (!rst_ni)
    cause_o <= 3'd4);

endmodule

bind chip_rst_seq chip_rst_seq_chk #(.N_PROG(N_PROG)) u_chk (
  .aon_clk_i   (aon_clk_i),
  .line_clk_i  (line_clk_i),
  .rst_ni      (rst_ni),
  .core_rst_no (core_rst_no),
  .rst_ind_no  (rst_ind_no),
  .oe_fixed_o  (oe_fixed_o),
  .oe_prog_o   (oe_prog_o),
  .cause_o     (cause_o)
);

// File: tb/chip_rst_seq_bench.sv
`timescale 1ns/1ps
module chip_rst_seq_bench;

  localparam int N_PROG = 8;
  localparam int IND    = 128;

  logic              aon_clk = 1'b0;
  logic              line_clk = 1'b0;
  logic              line_run = 1'b1;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1;
  logic              dig_uv = 1'b0;
  logic              ana_uv = 1'b0;
  logic              oe_we = 1'b0;
  logic [N_PROG-1:0] oe_wdata = '0;
  logic              cause_clr = 1'b0;
  logic              core_rst_n, ind_n;
  logic [2:0]        oe_fixed;
  logic [N_PROG-1:0] oe_prog;
  logic [2:0]        cause;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  chip_rst_seq #(.WD_LIMIT(16), .IND_CYCLES(IND), .N_PROG(N_PROG)) u_chip_rst_seq (
    .aon_clk_i   (aon_clk),
    .rst_ni      (rst_n),
    .line_clk_i  (line_clk),
    .chip_en_ni  (ce_n),
    .dig_uv_i    (dig_uv),
    .ana_uv_i    (ana_uv),
    .oe_we_i     (oe_we),
    .oe_wdata_i  (oe_wdata),
    .cause_clr_i (cause_clr),
    .core_rst_no (core_rst_n),
    .rst_ind_no  (ind_n),
    .oe_fixed_o  (oe_fixed),
    .oe_prog_o   (oe_prog),
    .cause_o     (cause)
  );

  always #2 aon_clk = ~aon_clk;

  // odd-ns edges keep line edges clear of aon edges
  initial begin
    #1;
    forever begin
      #10;
      if (line_run) line_clk = ~line_clk;
    end
  end

  // [7] stop line clock, [6] chip enable low, [5] analog flag, [4] digital flag, [2:0] expected code
  localparam logic [7:0] VEC [6] = '{8'h12, 8'h23, 8'h44, 8'h81, 8'h32, 8'h63};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic aon_wait(input int n);
    repeat (n) @(negedge aon_clk);
  endtask

  task automatic line_write(input logic [N_PROG-1:0] val);
    @(negedge line_clk);
    oe_we = 1'b1;
    oe_wdata = val;
    @(negedge line_clk);
    oe_we = 1'b0;
  endtask

  // counts line cycles with core out of reset and indicator low
  task automatic measure_ind(output int lowc, output bit ok);
    lowc = 0;
    ok = 1'b0;
    for (int g = 0; g < 3000; g++) begin
      @(negedge line_clk);
      if (core_rst_n && ind_n) begin
        ok = 1'b1;
        break;
      end
      if (core_rst_n) lowc++;
      else lowc = 0;
    end
  endtask

  task automatic wait_core(output int dt);
    int t0;
    t0 = int'($time);
    dt = -1;
    for (int g = 0; g < 2000; g++) begin
      if (core_rst_n) begin
        dt = int'($time) - t0;
        break;
      end
      #1;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lowc;
    bit ok;
    int dt;
    logic [7:0] v;

    // power-on reset state
    aon_wait(10);
    chk(core_rst_n == 1'b0, "R1 core in power-on reset", core_rst_n, 0);
    chk(ind_n == 1'b0, "R1 indicator in power-on reset", ind_n, 0);
    chk(oe_fixed == 3'b000, "R1 fixed enables off", oe_fixed, 0);
    chk(oe_prog == '0, "R1 prog enables off", oe_prog, 0);
    chk(cause == 3'd0, "R8 code after power-on", cause, 0);
    @(negedge aon_clk);
    rst_n = 1'b1;
    measure_ind(lowc, ok);
    chk(ok && lowc == IND, "R4 indicator length after power-on", lowc, IND);
    chk(oe_fixed == 3'b111, "R6 fixed enables back", oe_fixed, 7);
    chk(oe_prog == '0, "R7 prog enables off after reset", oe_prog, 0);

    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      line_write(8'hFF);
      chk(oe_prog == 8'hFF, "R7 prog write", oe_prog, 255);
      @(negedge aon_clk);
      dig_uv = v[4];
      ana_uv = v[5];
      ce_n = ~v[6];
      if (v[7]) line_run = 1'b0;
      aon_wait(60);
      chk(core_rst_n == 1'b0, v[7] ? "R2 missing clock resets core" : "R1 cause resets core", core_rst_n, 0);
      chk(ind_n == 1'b0, "R1 indicator low", ind_n, 0);
      chk(oe_fixed == 3'b000, "R1 R6 fixed enables off", oe_fixed, 0);
      chk(oe_prog == '0, "R1 R7 prog enables off", oe_prog, 0);
      chk(cause == v[2:0], "R8 cause code", cause, int'(v[2:0]));
      if (!v[7]) line_write(8'hA5);
      @(negedge aon_clk);
      dig_uv = 1'b0;
      ana_uv = 1'b0;
      ce_n = 1'b1;
      line_run = 1'b1;
      wait_core(dt);
      if (!v[7]) chk(dt >= 30 && dt <= 55, "R3 release latency ns", dt, 40);
      else chk(dt > 0, "R2 clock recovery releases reset", dt, 1);
      measure_ind(lowc, ok);
      chk(ok && lowc == IND, "R4 indicator length", lowc, IND);
      chk(oe_fixed == 3'b111, "R6 fixed enables back", oe_fixed, 7);
      chk(oe_prog == '0, "R7 write in reset ignored, prog cleared", oe_prog, 0);
      chk(cause == v[2:0], "R8 code held", cause, int'(v[2:0]));
    end

    // restart of indicator count
    @(negedge aon_clk);
    dig_uv = 1'b1;
    aon_wait(10);
    dig_uv = 1'b0;
    wait_core(dt);
    repeat (40) @(negedge line_clk);
    chk(ind_n == 1'b0 && core_rst_n == 1'b1, "R5 indicator counting", ind_n, 0);
    @(negedge aon_clk);
    ana_uv = 1'b1;
    aon_wait(5);
    ana_uv = 1'b0;
    aon_wait(3);
    chk(core_rst_n == 1'b0, "R5 cause reappears resets core", core_rst_n, 0);
    measure_ind(lowc, ok);
    chk(ok && lowc == IND, "R5 full count after restart", lowc, IND);
    chk(cause == 3'd3, "R8 latest cause", cause, 3);

    // software clear
    @(negedge aon_clk);
    cause_clr = 1'b1;
    @(negedge aon_clk);
    cause_clr = 1'b0;
    aon_wait(2);
    chk(cause == 3'd0, "R9 clear code", cause, 0);
    chk(core_rst_n && ind_n, "R9 clear leaves reset outputs", core_rst_n & ind_n, 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule